// File: doc/BRIEF.md
# Programmable Flag Threshold Loader

This block stores the two thresholds that a FIFO's almost-empty and almost-full flag logic compares against: an empty offset and a full offset, each 16 bits wide. The level of the load strap while master reset is held picks one of two programming methods. It also picks the values both offsets take at reset. With the strap high, the block uses bit-serial loading, and both offsets reset to 1,023 (high byte 0x03, low byte 0xFF). With the strap low, it uses byte-wide parallel loading, and both offsets reset to 127 (high byte 0x00, low byte 0x7F). The method can change only at master reset. The offset values can be rewritten at any time after reset.

The storage holds four byte slots in a fixed order, treated as one 32-bit word: slot 0 is the empty offset low byte (bits 7:0), slot 1 the empty high byte (15:8), slot 2 the full low byte (23:16) and slot 3 the full high byte (31:24). Parallel writes use a write pointer, and parallel read-back uses a separate read pointer. Each pointer walks slots 0 to 3 and wraps. Serial loading writes one bit per write-clock edge. It starts at the empty offset's bit 0 and ends at the full offset's bit 15, then wraps. When the load input is low, the write and read enables go to the FIFO memory and not to the offset storage.

The write side has a two-state mode register, ST_PARALLEL or ST_SERIAL. Reset loads it from the strap, and it has no other transitions. Each write-clock cycle is decoded into one operation: OP_NONE, OP_PAR_WR, OP_SER_SHIFT or OP_MEMORY.

Top module: `flag_ofs_loader`

## Requirements
- R1: A master reset taken with the load strap high selects serial mode and sets both offsets to 0x03FF.
- R2: A master reset taken with the load strap low selects parallel mode and sets both offsets to 0x007F.
- R3: In parallel mode, with load high, each write-clock edge with write enable stores din_i[7:0] into the slot under the write pointer, in the order empty low, empty high, full low, full high, and then wraps to empty low.
- R4: With load high, each read-clock edge with read enable places the slot under the read pointer on rd_data_o[7:0], with bit 8 at zero. The slot order and the wrap are the same as for writes. Read-back works in both modes.
- R5: In serial mode, with load high, each write-clock edge with serial enable stores si_i into the next bit: empty bit 0 up to empty bit 15, then full bit 0 up to full bit 15, then back to empty bit 0.
- R6: Serial enable has no effect in parallel mode, and parallel writes have no effect in serial mode.
- R7: With load low, the offsets and rd_data_o do not change. mem_we_o and mem_re_o follow the write and read enables, and both are low whenever load is high.
- R8: With load high and no enable active, the offsets and rd_data_o hold their values.
- R9: The write pointer and the read pointer advance independently, and master reset returns both to the empty low slot. rd_data_o is zero after reset.
- R10: Changes on the load input after reset do not change the programming mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| mrst_i | input | 1 | Master reset, active high, synchronous to each clock |
| ld_i | input | 1 | Load strap at reset; selects the offset registers when high |
| wen_i | input | 1 | Write enable, active high |
| ren_i | input | 1 | Read enable, active high |
| sen_i | input | 1 | Serial shift enable, active high |
| si_i | input | 1 | Serial data bit |
| din_i | input | 9 | Data-in bus; bits 7:0 are used for offset bytes |
| empty_ofs_o | output | 16 | Empty offset to the flag logic |
| full_ofs_o | output | 16 | Full offset to the flag logic |
| rd_data_o | output | 9 | Offset read-back byte, bit 8 zero |
| mem_we_o | output | 1 | Write enable passed to the FIFO memory |
| mem_re_o | output | 1 | Read enable passed to the FIFO memory |

## Verification
The assertions run every cycle. They check that the mode never changes outside reset, that storage and read-back hold when load is high and no enable is active, that nothing changes while load is low, and that the first parallel byte and the first serial bit reach slot 0 and bit 0. Some behaviour can only be shown by the bench's scenarios. This includes the full walk-and-wrap order of both pointers, the independence of the two pointers when a write and a read happen in the same cycle, the exact strap defaults, and the value assembled from 32 serial bits.

// File: rtl/flag_ofs_pkg.sv
package flag_ofs_pkg;

    // Programming method latched from the strap at master reset
    typedef enum logic {
        ST_PARALLEL = 1'b0,
        ST_SERIAL   = 1'b1
    } load_mode_e;

    // Operation decoded for one write-clock cycle
    typedef enum logic [1:0] {
        OP_NONE      = 2'd0,
        OP_PAR_WR    = 2'd1,
        OP_SER_SHIFT = 2'd2,
        OP_MEMORY    = 2'd3
    } wr_op_e;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/flag_ofs_wr_ctrl.sv
module flag_ofs_wr_ctrl
    import flag_ofs_pkg::*;
#(
    parameter int OFS_W = 16,
    parameter int DIN_W = 9,
    parameter logic [OFS_W-1:0] DEF_SER = 16'h03FF,
    parameter logic [OFS_W-1:0] DEF_PAR = 16'h007F
) (
    input  logic                 clk,
    input  logic                 mrst,
    input  logic                 ld,
    input  logic                 wen,
    input  logic                 sen,
    input  logic                 si,
    input  logic [DIN_W-1:0]     din,
    output logic [2*OFS_W-1:0]   ofs_o
);
    localparam int BYTES_PER = OFS_W / BYTE_W;
    localparam int NSLOT     = 2 * BYTES_PER;
    localparam int PTR_W     = (NSLOT > 1) ? $clog2(NSLOT) : 1;
    localparam int NBIT      = 2 * OFS_W;
    localparam int SIDX_W    = $clog2(NBIT);
    localparam logic [PTR_W-1:0]  PTR_LAST  = PTR_W'(NSLOT - 1);
    localparam logic [SIDX_W-1:0] SIDX_LAST = SIDX_W'(NBIT - 1);

    load_mode_e           mode_q, mode_d;
    wr_op_e               op;
    logic [NBIT-1:0]      ofs_q;
    logic [PTR_W-1:0]     wptr_q;
    logic [SIDX_W-1:0]    sidx_q;

    // Next-state logic: the mode leaves its state only through reset
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            ST_PARALLEL: mode_d = ST_PARALLEL;
            ST_SERIAL:   mode_d = ST_SERIAL;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (mrst)
            mode_q <= ld ? ST_SERIAL : ST_PARALLEL;
        else
            mode_q <= mode_d;
    end

    // Operation decode
    always_comb begin
        op = OP_NONE;
        if (!ld) begin
            op = OP_MEMORY;
        end else begin
            unique case (mode_q)
                ST_PARALLEL: if (wen) op = OP_PAR_WR;
                ST_SERIAL:   if (sen) op = OP_SER_SHIFT;
            endcase
        end
    end

    // Offset storage and pointers
    always_ff @(posedge clk) begin
        if (mrst) begin
            ofs_q  <= ld ? {DEF_SER, DEF_SER} : {DEF_PAR, DEF_PAR};
            wptr_q <= '0;
            sidx_q <= '0;
        end else begin
            unique case (op)
                OP_PAR_WR: begin
                    ofs_q[wptr_q*BYTE_W +: BYTE_W] <= din[BYTE_W-1:0];
                    wptr_q <= (wptr_q == PTR_LAST) ? '0 : wptr_q + 1'b1;
                end
                OP_SER_SHIFT: begin
                    ofs_q[sidx_q] <= si;
                    sidx_q <= (sidx_q == SIDX_LAST) ? '0 : sidx_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign ofs_o = ofs_q;

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (mrst)
        !mrst |=> $stable(mode_q)); // R10

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (mrst)
        (ld && !wen && !sen) |=> $stable(ofs_q)); // R8

    AST_MEM_NO_TOUCH: assert property (@(posedge clk) disable iff (mrst)
        !ld |=> $stable(ofs_q)); // R7

    AST_PAR_FIRST_SLOT: assert property (@(posedge clk) disable iff (mrst)
        (op == OP_PAR_WR && wptr_q == '0) |=> ofs_q[BYTE_W-1:0] == $past(din[BYTE_W-1:0])); // R3

    AST_SER_FIRST_BIT: assert property (@(posedge clk) disable iff (mrst)
        (op == OP_SER_SHIFT && sidx_q == '0) |=> ofs_q[0] == $past(si)); // R5

endmodule

// File: rtl/flag_ofs_rd_port.sv
module flag_ofs_rd_port
    import flag_ofs_pkg::*;
#(
    parameter int OFS_W = 16,
    parameter int DIN_W = 9
) (
    input  logic                 clk,
    input  logic                 mrst,
    input  logic                 ld,
    input  logic                 ren,
    input  logic [2*OFS_W-1:0]   ofs_i,
    output logic [DIN_W-1:0]     rd_data_o
);
    localparam int NSLOT = 2 * (OFS_W / BYTE_W);
    localparam int PTR_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;
    localparam int PAD_W = DIN_W - BYTE_W;
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(NSLOT - 1);

    logic [PTR_W-1:0]  rptr_q;
    logic [BYTE_W-1:0] rd_q;
    logic              take;

    assign take = ld && ren;

    always_ff @(posedge clk) begin
        if (mrst) begin
            rptr_q <= '0;
            rd_q   <= '0;
        end else if (take) begin
            rd_q   <= ofs_i[rptr_q*BYTE_W +: BYTE_W];
            rptr_q <= (rptr_q == PTR_LAST) ? '0 : rptr_q + 1'b1;
        end
    end

    generate
        if (PAD_W > 0) begin : g_pad
            assign rd_data_o = {{PAD_W{1'b0}}, rd_q};
        end else begin : g_nopad
            assign rd_data_o = rd_q[DIN_W-1:0];
        end
    endgenerate

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (mrst)
        !take |=> $stable(rd_data_o)); // R8

    AST_RD_FIRST_SLOT: assert property (@(posedge clk) disable iff (mrst)
        (take && rptr_q == '0) |=> rd_data_o[BYTE_W-1:0] == $past(ofs_i[BYTE_W-1:0])); // R4

endmodule

// File: rtl/flag_ofs_loader.sv
module flag_ofs_loader
    import flag_ofs_pkg::*;
#(
    parameter int OFS_W = 16,
    parameter int DIN_W = 9,
    parameter logic [OFS_W-1:0] DEF_SER = 16'h03FF,
    parameter logic [OFS_W-1:0] DEF_PAR = 16'h007F
) (
    input  logic               wclk_i,
    input  logic               rclk_i,
    input  logic               mrst_i,
    input  logic               ld_i,
    input  logic               wen_i,
    input  logic               ren_i,
    input  logic               sen_i,
    input  logic               si_i,
    input  logic [DIN_W-1:0]   din_i,
    output logic [OFS_W-1:0]   empty_ofs_o,
    output logic [OFS_W-1:0]   full_ofs_o,
    output logic [DIN_W-1:0]   rd_data_o,
    output logic               mem_we_o,
    output logic               mem_re_o
);
    logic [2*OFS_W-1:0] ofs;

    flag_ofs_wr_ctrl #(
        .OFS_W(OFS_W), .DIN_W(DIN_W), .DEF_SER(DEF_SER), .DEF_PAR(DEF_PAR)
    ) u_wr (
        .clk(wclk_i), .mrst(mrst_i), .ld(ld_i), .wen(wen_i),
        .sen(sen_i), .si(si_i), .din(din_i), .ofs_o(ofs)
    );

    flag_ofs_rd_port #(
        .OFS_W(OFS_W), .DIN_W(DIN_W)
    ) u_rd (
        .clk(rclk_i), .mrst(mrst_i), .ld(ld_i), .ren(ren_i),
        .ofs_i(ofs), .rd_data_o(rd_data_o)
    );

    assign empty_ofs_o = ofs[OFS_W-1:0];
    assign full_ofs_o  = ofs[2*OFS_W-1:OFS_W];
    assign mem_we_o    = wen_i && !ld_i;
    assign mem_re_o    = ren_i && !ld_i;

    AST_RD_STILL_WHEN_MEM: assert property (@(posedge rclk_i) disable iff (mrst_i)
        !ld_i |=> $stable(rd_data_o)); // R7

endmodule

// File: tb/flag_ofs_loader_test.sv
module flag_ofs_loader_test;

    logic       clk = 1'b0;
    logic       mrst, ld, wen, ren, sen, si;
    logic [8:0] din;
    logic [15:0] e_ofs, f_ofs;
    logic [8:0] rd;
    logic       mwe, mre;
    int         total = 0;
    int         bad = 0;
    bit         done = 0;

    always #4 clk = ~clk;

    flag_ofs_loader uut (
        .wclk_i(clk), .rclk_i(clk), .mrst_i(mrst), .ld_i(ld),
        .wen_i(wen), .ren_i(ren), .sen_i(sen), .si_i(si), .din_i(din),
        .empty_ofs_o(e_ofs), .full_ofs_o(f_ofs), .rd_data_o(rd),
        .mem_we_o(mwe), .mem_re_o(mre)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic        l, w, r, s, b;
        logic [8:0]  d;
        logic [15:0] exp_e, exp_f;
        logic [8:0]  exp_rd;
    } vec_t;

    // Walked after a parallel-mode reset (e=f=007F, rd=000)
    localparam vec_t TBL [15] = '{
        '{4'd3,  1'b1,1'b1,1'b0,1'b0,1'b0, 9'h012, 16'h0012, 16'h007F, 9'h000}, // R3 empty low
        '{4'd3,  1'b1,1'b1,1'b0,1'b0,1'b0, 9'h134, 16'h3412, 16'h007F, 9'h000}, // R3 empty high
        '{4'd3,  1'b1,1'b1,1'b0,1'b0,1'b0, 9'h056, 16'h3412, 16'h0056, 9'h000}, // R3 full low
        '{4'd3,  1'b1,1'b1,1'b0,1'b0,1'b0, 9'h078, 16'h3412, 16'h7856, 9'h000}, // R3 full high
        '{4'd3,  1'b1,1'b1,1'b0,1'b0,1'b0, 9'h0AB, 16'h34AB, 16'h7856, 9'h000}, // R3 wrap
        '{4'd8,  1'b1,1'b0,1'b0,1'b0,1'b0, 9'h0EE, 16'h34AB, 16'h7856, 9'h000}, // R8 idle
        '{4'd4,  1'b1,1'b0,1'b1,1'b0,1'b0, 9'h000, 16'h34AB, 16'h7856, 9'h0AB}, // R4 slot 0
        '{4'd4,  1'b1,1'b0,1'b1,1'b0,1'b0, 9'h000, 16'h34AB, 16'h7856, 9'h034}, // R4 slot 1
        '{4'd4,  1'b1,1'b0,1'b1,1'b0,1'b0, 9'h000, 16'h34AB, 16'h7856, 9'h056}, // R4 slot 2
        '{4'd4,  1'b1,1'b0,1'b1,1'b0,1'b0, 9'h000, 16'h34AB, 16'h7856, 9'h078}, // R4 slot 3
        '{4'd4,  1'b1,1'b0,1'b1,1'b0,1'b0, 9'h000, 16'h34AB, 16'h7856, 9'h0AB}, // R4 wrap
        '{4'd6,  1'b1,1'b0,1'b0,1'b1,1'b1, 9'h000, 16'h34AB, 16'h7856, 9'h0AB}, // R6 serial ignored
        '{4'd7,  1'b0,1'b1,1'b1,1'b1,1'b1, 9'h0FF, 16'h34AB, 16'h7856, 9'h0AB}, // R7 memory access
        '{4'd9,  1'b1,1'b1,1'b1,1'b0,1'b0, 9'h0CD, 16'hCDAB, 16'h7856, 9'h034}, // R9 independent pointers
        '{4'd9,  1'b1,1'b1,1'b0,1'b0,1'b0, 9'h1EF, 16'hCDAB, 16'h78EF, 9'h034}  // R9 write pointer on
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic l, w, r, s, b, input logic [8:0] d);
        ld = l; wen = w; ren = r; sen = s; si = b; din = d;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset(input logic strap);
        mrst = 1'b1;
        drive(strap, 1'b0, 1'b0, 1'b0, 1'b0, 9'h000);
        step();
        step();
        mrst = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] pat;
        mrst = 1'b1;
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 9'h000);
        @(negedge clk);
        do_reset(1'b0);
        chk("R2 empty default", e_ofs, 16'h007F);
        chk("R2 full default", f_ofs, 16'h007F);
        chk("R9 rd after reset", {7'd0, rd}, 16'h0000);

        foreach (TBL[i]) begin
            drive(TBL[i].l, TBL[i].w, TBL[i].r, TBL[i].s, TBL[i].b, TBL[i].d);
            step();
            chk($sformatf("R%0d row %0d empty", TBL[i].req, i), e_ofs, TBL[i].exp_e);
            chk($sformatf("R%0d row %0d full", TBL[i].req, i), f_ofs, TBL[i].exp_f);
            chk($sformatf("R%0d row %0d rd", TBL[i].req, i), {7'd0, rd}, {7'd0, TBL[i].exp_rd});
        end

        // R7: memory enables follow wen/ren only while load is low
        drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 9'h000);
        #1;
        chk("R7 mem_we with load low", {15'd0, mwe}, 16'd1);
        chk("R7 mem_re with load low", {15'd0, mre}, 16'd1);
        drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 9'h000);
        #1;
        chk("R7 mem_we with load high", {15'd0, mwe}, 16'd0);
        chk("R7 mem_re with load high", {15'd0, mre}, 16'd0);
        drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 9'h000);
        step();

        // R1: serial strap defaults
        do_reset(1'b1);
        chk("R1 empty default", e_ofs, 16'h03FF);
        chk("R1 full default", f_ofs, 16'h03FF);
        chk("R9 rd after serial reset", {7'd0, rd}, 16'h0000);

        // R10 / R6: load toggled after reset, then a parallel write is ignored
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 9'h000);
        step();
        drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 9'h055);
        step();
        chk("R6 parallel write in serial mode", e_ofs, 16'h03FF);
        chk("R10 mode kept after strap change", f_ofs, 16'h03FF);

        // R5: 32 serial bits, empty bit 0 first
        pat = 32'h1E69A5C3;
        for (int k = 0; k < 16; k++) begin
            drive(1'b1, 1'b0, 1'b0, 1'b1, pat[k], 9'h000);
            step();
        end
        chk("R5 empty after 16 bits", e_ofs, 16'hA5C3);
        chk("R5 full untouched after 16 bits", f_ofs, 16'h03FF);
        for (int k = 16; k < 32; k++) begin
            drive(1'b1, 1'b0, 1'b0, 1'b1, pat[k], 9'h000);
            step();
        end
        chk("R5 full after 32 bits", f_ofs, 16'h1E69);
        drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 9'h000);
        step();
        chk("R5 wrap to empty bit 0", e_ofs, 16'hA5C2);

        // R7: serial enable with load low does nothing
        drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 9'h000);
        step();
        chk("R7 shift with load low", e_ofs, 16'hA5C2);

        // R4: read-back allowed in serial mode
        drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 9'h000);
        step();
        chk("R4 serial-mode read slot 0", {7'd0, rd}, 16'h00C2);
        step();
        chk("R4 serial-mode read slot 1", {7'd0, rd}, 16'h00A5);

        // R9: reset returns both pointers to slot 0
        do_reset(1'b0);
        drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 9'h000);
        step();
        chk("R9 read pointer reset", {7'd0, rd}, 16'h007F);
        drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 9'h011);
        step();
        chk("R9 write pointer reset", e_ofs, 16'h0011);
        chk("R9 full kept", f_ofs, 16'h007F);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule